// File: doc/BRIEF.md
# Periodic Credit Rate Limiter Bank

A bank of independent token-bucket limiters for a transmit queue manager. Each limiter keeps a 32-bit credit counter in offset form: the value with only bit 31 set means zero credit, values above it are positive credit and values below it are a debt. A shared period timer produces a refill pulse every programmed number of clocks. On each pulse, every limiter adds its own increment, and the result is clamped at a fixed ceiling. Bytes reported on the consume port are subtracted from the addressed limiter in the same cycle. A limiter reports its flow as eligible while its credit is at or above zero.

Software programs the bank through a single-cycle register-style write port. The port sets the global enable, the refill period, the per-limiter increment, and a direct credit value. While the bank is disabled, the timer is held and every flow is reported eligible. An increment above the legal maximum is refused and flagged. The conversion from a rate to an increment is left to software.

Top module: `rate_limiter_bank`

## Requirements
- R1: After reset the bank is disabled, every eligible bit is 1, cfg_err is 0, every credit is zero (0x8000_0000), every increment is 0, and the refill period is 125 clocks.
- R2: While the global enable is 0, all eligible bits are 1 whatever the credit, and no refill happens. Consumes still deduct.
- R3: While enabled, the timer counts enabled clocks. refill_tick is high in the clock where the count reaches the period. The timer then restarts, so with period P a pulse occurs every P clocks. A period of 0 or 1 pulses every clock.
- R4: On a refill pulse each limiter's credit becomes min(credit + increment, 0x8000_0000 + 62,500,000).
- R5: A consume (use_valid, use_id, use_bytes) subtracts use_bytes from that limiter at the next clock edge. If a refill lands on the same limiter in the same cycle, the refill (with its clamp) is applied first and the subtraction second.
- R6: With the bank enabled, eligible[i] equals bit 31 of the credit, so it is 1 exactly when credit >= 0x8000_0000.
- R7: An increment write with data above 43,750,000 is refused. The old increment is kept, and cfg_err is 1 for the single following cycle. A write of exactly 43,750,000 is accepted.
- R8: An accepted increment write also loads that limiter's credit with zero (0x8000_0000).
- R9: A credit write loads cfg_data unchanged into the addressed limiter. Credit and increment writes take priority over refill and consume for that limiter.
- R10: A consume larger than the remaining raw credit leaves the raw credit at 0 and does not wrap.
- R11: A period write restarts the timer count from zero.
- R12: Write port encoding on cfg_sel: 0 sets the enable from cfg_data[0]; 1 sets the period from cfg_data[PER_W-1:0]; 2 writes the increment of limiter cfg_id; 3 writes the credit of limiter cfg_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target (R12 encoding) |
| cfg_id | input | ID_W | Limiter addressed by increment and credit writes |
| cfg_data | input | 32 | Write data |
| use_valid | input | 1 | Consume strobe |
| use_id | input | ID_W | Limiter charged |
| use_bytes | input | BYTE_W | Bytes deducted |
| eligible | output | NUM_LIM | Per-limiter send permission |
| cfg_err | output | 1 | One-cycle pulse after a refused increment |
| refill_tick | output | 1 | High in the cycle a refill is applied |

## Verification
The bench drives credit up to the ceiling and then drains exactly the ceiling amount, so it ends on the zero point. A design that clamps one count off, or uses a strict compare for eligibility, shows the wrong eligible bit there. It overdraws a small positive credit: a subtractor that wraps sets bit 31 again and reports a broke flow as eligible. It writes increments one above and exactly at the legal maximum, aligns consumes with refill pulses at period 1, and counts clocks from enable to the first pulse, which exposes an off-by-one timer. Random configuration and consume traffic, including mid-count period changes, is compared every cycle against a bench model.

// File: rtl/rl_pkg.sv
// Shared constants and write-port encoding for the credit rate limiter bank.
// Assumes 32-bit credits in offset form with bit 31 as the zero marker.
package rl_pkg;
    localparam int          CRD_W      = 32;
    localparam logic [31:0] CRD_ZERO   = 32'h8000_0000;
    localparam logic [31:0] CRD_CEIL   = CRD_ZERO + 32'd62_500_000;
    localparam logic [31:0] INC_MAX    = 32'd43_750_000;
    localparam int          PERIOD_RST = 125;

    typedef enum logic [1:0] {
        CFG_ENABLE = 2'd0,
        CFG_PERIOD = 2'd1,
        CFG_INC    = 2'd2,
        CFG_CREDIT = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/rl_cfg_regs.sv
// Configuration register file: global enable, refill period and per-limiter
// increments. It checks increments against the legal maximum and decodes the
// per-limiter credit load strobes. Assumes single-cycle writes.
module rl_cfg_regs
    import rl_pkg::*;
#(
    parameter int NUM_LIM = 4,
    parameter int PER_W   = 16,
    localparam int ID_W   = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_valid,
    input  logic [1:0]                      cfg_sel,
    input  logic [ID_W-1:0]                 cfg_id,
    input  logic [31:0]                     cfg_data,
    output logic                            lim_en,
    output logic [PER_W-1:0]                lim_period,
    output logic                            period_wr,
    output logic [NUM_LIM-1:0][CRD_W-1:0]   inc_vec,
    output logic [NUM_LIM-1:0]              zero_ld,
    output logic [NUM_LIM-1:0]              val_ld,
    output logic                            cfg_err
);
    logic inc_wr, inc_ok, id_ok;

    assign id_ok     = int'(cfg_id) < NUM_LIM;
    assign inc_wr    = cfg_valid && (cfg_sel == CFG_INC);
    assign inc_ok    = inc_wr && (cfg_data <= INC_MAX);
    assign period_wr = cfg_valid && (cfg_sel == CFG_PERIOD);

    // Register writes, with the error pulse for a refused increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_en     <= 1'b0;
            lim_period <= PER_W'(PERIOD_RST);
            cfg_err    <= 1'b0;
            inc_vec    <= '0;
        end else begin
            cfg_err <= inc_wr && !inc_ok;
            if (cfg_valid && cfg_sel == CFG_ENABLE) lim_en <= cfg_data[0];
            if (period_wr) lim_period <= cfg_data[PER_W-1:0];
            if (inc_ok && id_ok) inc_vec[cfg_id] <= cfg_data;
        end
    end

    // Per-limiter credit load strobes
    for (genvar gi = 0; gi < NUM_LIM; gi++) begin : g_ld
        assign zero_ld[gi] = inc_ok && (cfg_id == ID_W'(gi));
        assign val_ld[gi]  = cfg_valid && (cfg_sel == CFG_CREDIT) && (cfg_id == ID_W'(gi));
    end
endmodule

// File: rtl/rl_period_timer.sv
// Refill period timer. It counts enabled clocks and pulses tick on the clock
// where the count reaches the period, then restarts. It is held at zero
// while disabled and cleared when the period is rewritten.
module rl_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic             restart,
    output logic             tick
);
    logic [PER_W-1:0] cnt;

    assign tick = en && (((PER_W+1)'(cnt) + (PER_W+1)'(1)) >= (PER_W+1)'(period));

    // Count advance and wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (!en || restart || tick)   cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rl_credit_cell.sv
// One limiter's credit counter in offset form. A refill adds the increment
// and clamps at the ceiling. A consume then subtracts, with a floor at raw
// zero. Loads override both. Assumes BYTE_W < 32.
module rl_credit_cell
    import rl_pkg::*;
#(
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CRD_W-1:0]  inc,
    input  logic              zero_ld,
    input  logic              val_ld,
    input  logic [CRD_W-1:0]  ld_data,
    input  logic              use_hit,
    input  logic [BYTE_W-1:0] use_bytes,
    output logic [CRD_W-1:0]  credit
);
    logic [CRD_W:0]   sum;
    logic [CRD_W-1:0] refilled, drained, bytes_ext;

    // Refill with clamp, then saturating deduction
    always_comb begin
        sum       = {1'b0, credit} + {1'b0, inc};
        bytes_ext = CRD_W'(use_bytes);
        refilled  = credit;
        if (tick) refilled = (sum > {1'b0, CRD_CEIL}) ? CRD_CEIL : sum[CRD_W-1:0];
        drained = refilled;
        if (use_hit) drained = (refilled < bytes_ext) ? '0 : refilled - bytes_ext;
    end

    // Credit register update with load priority
    always_ff @(posedge clk) begin
        if (!rst_n)       credit <= CRD_ZERO;
        else if (zero_ld) credit <= CRD_ZERO;
        else if (val_ld)  credit <= ld_data;
        else              credit <= drained;
    end
endmodule

// File: rtl/rate_limiter_bank.sv
// Bank of NUM_LIM credit rate limiters sharing one refill timer. Eligibility
// is forced high while the bank is disabled. Assumes use_id and cfg_id only
// address existing limiters.
module rate_limiter_bank
    import rl_pkg::*;
#(
    parameter int NUM_LIM = 4,
    parameter int BYTE_W  = 16,
    parameter int PER_W   = 16,
    localparam int ID_W   = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_sel,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic [31:0]        cfg_data,
    input  logic               use_valid,
    input  logic [ID_W-1:0]    use_id,
    input  logic [BYTE_W-1:0]  use_bytes,
    output logic [NUM_LIM-1:0] eligible,
    output logic               cfg_err,
    output logic               refill_tick
);
    logic                          lim_en, period_wr, tick;
    logic [PER_W-1:0]              lim_period;
    logic [NUM_LIM-1:0][CRD_W-1:0] inc_vec, crd_vec;
    logic [NUM_LIM-1:0]            zero_ld, val_ld, use_hit;

    rl_cfg_regs #(.NUM_LIM(NUM_LIM), .PER_W(PER_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
        .cfg_id(cfg_id), .cfg_data(cfg_data), .lim_en(lim_en),
        .lim_period(lim_period), .period_wr(period_wr), .inc_vec(inc_vec),
        .zero_ld(zero_ld), .val_ld(val_ld), .cfg_err(cfg_err)
    );

    rl_period_timer #(.PER_W(PER_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(lim_en), .period(lim_period),
        .restart(period_wr), .tick(tick)
    );

    for (genvar gi = 0; gi < NUM_LIM; gi++) begin : g_lim
        assign use_hit[gi] = use_valid && (use_id == ID_W'(gi));

        rl_credit_cell #(.BYTE_W(BYTE_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .tick(tick), .inc(inc_vec[gi]),
            .zero_ld(zero_ld[gi]), .val_ld(val_ld[gi]), .ld_data(cfg_data),
            .use_hit(use_hit[gi]), .use_bytes(use_bytes), .credit(crd_vec[gi])
        );

        assign eligible[gi] = !lim_en || crd_vec[gi][CRD_W-1];
    end

    assign refill_tick = tick;
endmodule

// File: rtl/rl_bank_chk.sv
// Property checker for rate_limiter_bank, attached by bind. It observes the
// bank's ports and its enable, period and credit state.
module rl_bank_chk
    import rl_pkg::*;
#(
    parameter int NUM_LIM = 4,
    parameter int PER_W   = 16,
    localparam int ID_W   = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_valid,
    input logic [1:0]                    cfg_sel,
    input logic [ID_W-1:0]               cfg_id,
    input logic [31:0]                   cfg_data,
    input logic [NUM_LIM-1:0]            eligible,
    input logic                          cfg_err,
    input logic                          refill_tick,
    input logic                          lim_en,
    input logic [PER_W-1:0]              lim_period,
    input logic [NUM_LIM-1:0][CRD_W-1:0] crd_vec
);
    // R2
    dis_all_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_en |-> &eligible);

    // R3
    tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_tick |-> lim_en);

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_tick && lim_period > PER_W'(1) && !(cfg_valid && cfg_sel == CFG_PERIOD))
        |=> !refill_tick);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_valid && cfg_sel == CFG_INC && cfg_data > INC_MAX));

    for (genvar gi = 0; gi < NUM_LIM; gi++) begin : g_chk
        // R8
        inc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_valid && cfg_sel == CFG_INC && cfg_id == ID_W'(gi) && cfg_data <= INC_MAX)
            |=> crd_vec[gi] == CRD_ZERO);

        // R9
        crd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_valid && cfg_sel == CFG_CREDIT && cfg_id == ID_W'(gi))
            |=> crd_vec[gi] == $past(cfg_data));
    end
endmodule

bind rate_limiter_bank rl_bank_chk #(.NUM_LIM(NUM_LIM), .PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .cfg_id(cfg_id), .cfg_data(cfg_data), .eligible(eligible),
    .cfg_err(cfg_err), .refill_tick(refill_tick), .lim_en(lim_en),
    .lim_period(lim_period), .crd_vec(crd_vec)
);

// File: tb/sim_rate_limiter_bank.sv
module sim_rate_limiter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int BW = 16;
    localparam int PW = 16;
    localparam longint unsigned ZERO  = 64'h8000_0000;
    localparam longint unsigned CEIL  = 64'h8000_0000 + 64'd62_500_000;
    localparam longint unsigned IMAX  = 64'd43_750_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [1:0]    cfg_id = '0;
    logic [31:0]   cfg_data = '0;
    logic          use_valid = 1'b0;
    logic [1:0]    use_id = '0;
    logic [BW-1:0] use_bytes = '0;
    logic [N-1:0]  eligible;
    logic          cfg_err, refill_tick;

    rate_limiter_bank #(.NUM_LIM(N), .BYTE_W(BW), .PER_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
        .cfg_id(cfg_id), .cfg_data(cfg_data), .use_valid(use_valid),
        .use_id(use_id), .use_bytes(use_bytes), .eligible(eligible),
        .cfg_err(cfg_err), .refill_tick(refill_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    longint unsigned m_crd[N], m_inc[N];
    longint unsigned m_per, m_cnt;
    bit m_en, m_err, last_tick;

    task automatic chk(string r, longint unsigned got, longint unsigned exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, got, exp);
        end
    endtask

    function automatic bit m_tick();
        return m_en && (m_cnt + 1 >= m_per);
    endfunction

    // One clock: check the refill pulse, advance the model, check outputs
    task automatic step();
        bit t;
        longint unsigned c, s;
        longint unsigned nxt[N];
        #2;
        last_tick = refill_tick;
        chk("R3", refill_tick, m_tick());
        t = m_tick();
        for (int i = 0; i < N; i++) begin
            c = m_crd[i];
            if (t) begin s = c + m_inc[i]; c = (s > CEIL) ? CEIL : s; end
            if (use_valid && use_id == 2'(i)) c = (c < use_bytes) ? 0 : c - use_bytes;
            if (cfg_valid && cfg_sel == 2'd2 && cfg_id == 2'(i) && cfg_data <= IMAX) c = ZERO;
            if (cfg_valid && cfg_sel == 2'd3 && cfg_id == 2'(i)) c = cfg_data;
            nxt[i] = c;
        end
        m_err = cfg_valid && cfg_sel == 2'd2 && cfg_data > IMAX;
        if (cfg_valid && cfg_sel == 2'd2 && cfg_data <= IMAX) m_inc[cfg_id] = cfg_data;
        if (!m_en || t || (cfg_valid && cfg_sel == 2'd1)) m_cnt = 0; else m_cnt++;
        if (cfg_valid && cfg_sel == 2'd1) m_per = cfg_data[PW-1:0];
        if (cfg_valid && cfg_sel == 2'd0) m_en = cfg_data[0];
        for (int i = 0; i < N; i++) m_crd[i] = nxt[i];
        @(posedge clk);
        #1;
        begin
            logic [N-1:0] ev;
            for (int i = 0; i < N; i++) ev[i] = !m_en || m_crd[i][31];
            chk(m_en ? "R6" : "R2", eligible, ev);
        end
        chk("R7", cfg_err, m_err);
    endtask

    task automatic cfg(logic [1:0] sel, logic [1:0] id, logic [31:0] d);
        cfg_valid = 1'b1; cfg_sel = sel; cfg_id = id; cfg_data = d;
        step();
        cfg_valid = 1'b0;
    endtask

    task automatic consume(logic [1:0] id, logic [BW-1:0] b);
        use_valid = 1'b1; use_id = id; use_bytes = b;
        step();
        use_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin m_crd[i] = ZERO; m_inc[i] = 0; end
        m_per = 125; m_cnt = 0; m_en = 0; m_err = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1", eligible, {N{1'b1}});
        chk("R1", cfg_err, 0);

        // R2 overdraw while disabled still eligible
        consume(2'd0, 16'd1000);
        chk("R2", eligible[0], 1);
        // R6 enabling exposes the debt
        cfg(2'd0, 2'd0, 32'd1);
        chk("R6", eligible[0], 0);
        // R1 reset period of 125 clocks
        cnt = 0;
        for (int k = 1; k <= 200; k++) begin
            step();
            if (last_tick) begin cnt = k; break; end
        end
        chk("R1", cnt, 125);

        // R7 increment one above the limit is refused, the limit itself accepted
        cfg(2'd2, 2'd1, 32'd43_750_001);
        chk("R7", cfg_err, 1);
        cfg(2'd2, 2'd1, 32'd43_750_000);
        chk("R7", cfg_err, 0);

        // R4 saturation at the ceiling, R11 period write
        cfg(2'd1, 2'd0, 32'd2);
        idle(12);
        cfg(2'd0, 2'd0, 32'd0);
        for (int k = 0; k < 953; k++) consume(2'd1, 16'hFFFF);
        consume(2'd1, 16'd45145);
        cfg(2'd1, 2'd0, 32'd125);
        cfg(2'd0, 2'd0, 32'd1);
        chk("R4", eligible[1], 1);
        consume(2'd1, 16'd1);
        chk("R4", eligible[1], 0);

        // R9 credit writes around the zero point
        cfg(2'd3, 2'd2, 32'h7FFF_FFFF);
        chk("R9", eligible[2], 0);
        cfg(2'd3, 2'd2, 32'h8000_0000);
        chk("R9", eligible[2], 1);
        // R8 accepted increment write restores zero credit
        cfg(2'd3, 2'd2, 32'h7FFF_FFCE);
        cfg(2'd2, 2'd2, 32'd500);
        chk("R8", eligible[2], 1);
        // R10 overdraw floors at raw zero instead of wrapping
        cfg(2'd3, 2'd3, 32'd5);
        consume(2'd3, 16'd100);
        chk("R10", eligible[3], 0);

        // R5 refill and consume in the same cycle, period 1
        cfg(2'd2, 2'd3, 32'd100);
        cfg(2'd1, 2'd0, 32'd1);
        for (int k = 0; k < 5; k++) consume(2'd3, 16'd100);
        chk("R5", eligible[3], 1);
        consume(2'd3, 16'd101);
        chk("R5", eligible[3], 0);

        // R12 random traffic across all write targets
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 100 < 6) begin
                cfg_valid = 1'b1;
                cfg_sel = 2'($urandom % 4);
                cfg_id = 2'($urandom % N);
                case (cfg_sel)
                    2'd0: cfg_data = ($urandom % 10 < 9) ? 32'd1 : 32'd0;
                    2'd1: cfg_data = 1 + $urandom % 20;
                    2'd2: cfg_data = ($urandom % 8 == 0) ? 32'd43_750_001 + $urandom % 1000
                                                         : $urandom % 2_000_000;
                    default: cfg_data = 32'h8000_0000 - 100_000 + $urandom % 300_000;
                endcase
            end
            if ($urandom % 100 < 60) begin
                use_valid = 1'b1;
                use_id = 2'($urandom % N);
                use_bytes = BW'($urandom);
            end
            step();
            cfg_valid = 1'b0;
            use_valid = 1'b0;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule